// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside an 8-bit CPU core. It collects interrupt events and holds one request flag and one enable flag for each maskable source. It applies a global mask flag and selects the most urgent pending entry from a fixed fourteen-entry table. It presents that entry's number and its 16-bit vector address to the core.

The table has the following entries:
- A reset entry, which is always taken first.
- Twelve maskable sources: nine internal event pulses and three external pins. Each pin is synchronized and edge-detected, and each has its own polarity bit.
- A software-break entry, which is always taken last.

The core reads and writes the flags through a small register window. When the core accepts the presented entry, it pulses `irqAck`. On that pulse the block clears the taken request, raises the mask flag and frees the arbiter for the next choice. The core itself handles the stack push and the vector fetch.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, these values hold: all request and enable bits are 0, all polarity bits are 0 and the mask flag (STAT bit 0) is 1. On the first clock after reset is released, the reset entry is presented with `irqSource`=0 and `irqVector`=16'hFFFE.
- R2: A maskable source is presented only when its request bit, its enable bit and a clear mask flag all hold together.
- R3: A CPU write to a request register clears each bit written as 0 and leaves each bit written as 1 unchanged. Bits 7:4 of the high request register are ignored. Request map: REQ_LO (address 0) holds sources 1..8 in bits 0..7, and REQ_HI (address 1) holds sources 9..12 in bits 0..3.
- R4: The core can read and write the following:
  - Enable bits: EN_LO at address 2 and EN_HI at address 3, with the same bit map as the request registers.
  - Polarity bits: POL at address 4, with bits 0..2 for pins 0..2.
  - The mask flag: STAT at address 5, bit 0.
  - Unused addresses read as 0.
- R5: Priority runs by entry number, lowest first:
  - 0: reset
  - 1: display done (intEvt[0])
  - 2: pin 1
  - 3: pin 0
  - 4..11: intEvt[1]..intEvt[8]
  - 12: pin 2
  - 13: software break

  The reset entry and the break entry ignore the mask flag and have no enable bit.
- R6: An acknowledge while an entry is presented has three effects on the next clock. It clears that entry's request (or the pending reset), sets the mask flag and drops `irqValid`.
- R7: Each pin passes through two synchronizer flops before edge detection. A polarity of 0 detects a low-to-high change and a polarity of 1 detects a high-to-low change. The request becomes readable after the third rising clock edge following the pin change.
- R8: The vector is 16'hFFFE minus twice the entry number. Once presented, the entry and its vector stay fixed until acknowledge, even if a more urgent source arrives.
- R9: A hardware event in the same cycle as a CPU clear, or as an acknowledge clear, leaves the request bit set.
- R10: A one-cycle pulse on an internal event input sets its request bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| extPin | input | 3 | External interrupt pins 0..2 |
| intEvt | input | 9 | Internal event pulses |
| brkReq | input | 1 | Software-break request, held by the core until acknowledged |
| regAddr | input | 3 | Register window address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational on regAddr |
| irqAck | input | 1 | Core accepts the presented entry |
| irqValid | output | 1 | An entry is being presented |
| irqSource | output | 4 | Presented entry number |
| irqVector | output | 16 | Presented vector address |

## Verification
The assertions check the following on every cycle:
- A presented entry holds steady until acknowledge.
- Acknowledge drops the presentation and raises the mask flag.
- No more than one request is cleared at once.
- A maskable entry never starts while the mask flag is set.
- A hardware event always wins over a clear.
- Writes never create a request bit.

Only the bench scenarios can show the rest, because each needs a directed sequence:
- The exact priority order and vector values.
- The three-edge pin latency.
- Polarity selection.
- The effect of each enable bit.
- Break behaviour while masked.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int NUM_EXT   = 3;
  localparam int NUM_INT   = 9;
  localparam int NUM_MASK  = NUM_EXT + NUM_INT;
  localparam int NUM_ENTRY = NUM_MASK + 2;
  localparam int IDX_W     = $clog2(NUM_ENTRY);
  localparam int HI_W      = NUM_MASK - 8;
  localparam logic [IDX_W-1:0] IDX_RESET = '0;
  localparam logic [IDX_W-1:0] IDX_BRK   = IDX_W'(NUM_ENTRY - 1);
  localparam logic [15:0] VEC_TOP = 16'hFFFE;

  localparam logic [2:0] A_REQ_LO = 3'd0;
  localparam logic [2:0] A_REQ_HI = 3'd1;
  localparam logic [2:0] A_EN_LO  = 3'd2;
  localparam logic [2:0] A_EN_HI  = 3'd3;
  localparam logic [2:0] A_POL    = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_MASK-1:0] clrReq;
    logic                clrReset;
    logic                setDisable;
  } strobe_t;

  function automatic logic [15:0] vecOf(input logic [IDX_W-1:0] idx);
    return VEC_TOP - {{(15-IDX_W){1'b0}}, idx, 1'b0};
  endfunction
endpackage

// File: rtl/irqc_datapath.sv
`timescale 1ns/1ps
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [NUM_INT-1:0]  intEvt,
  input  logic [2:0]          regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  strobe_t             strb,
  output logic [NUM_MASK-1:0] reqQ,
  output logic [NUM_MASK-1:0] enQ,
  output logic                disableQ,
  output logic                resetPendQ
);
  logic [NUM_EXT-1:0] syncQ [SYNC_STAGES];
  logic [NUM_EXT-1:0] prevQ, polQ, pinNow, extEdge;
  logic [NUM_MASK-1:0] setVec, swKeep;
  logic wrReqLo, wrReqHi, wrEnLo, wrEnHi, wrPol, wrStat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= extPin;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinNow  = syncQ[SYNC_STAGES-1];
  // changed, and new level differs from polarity (pol 0: rising, pol 1: falling)
  assign extEdge = (pinNow ^ prevQ) & (pinNow ^ polQ);
  // maskable bit order follows priority
  assign setVec  = {extEdge[2], intEvt[8:1], extEdge[0], extEdge[1], intEvt[0]};

  assign wrReqLo = regWrEn && (regAddr == A_REQ_LO);
  assign wrReqHi = regWrEn && (regAddr == A_REQ_HI);
  assign wrEnLo  = regWrEn && (regAddr == A_EN_LO);
  assign wrEnHi  = regWrEn && (regAddr == A_EN_HI);
  assign wrPol   = regWrEn && (regAddr == A_POL);
  assign wrStat  = regWrEn && (regAddr == A_STAT);

  always_comb begin
    swKeep = '1;
    if (wrReqLo) swKeep[7:0] = regWrData;
    if (wrReqHi) swKeep[NUM_MASK-1:8] = regWrData[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ       <= '0;
      enQ        <= '0;
      polQ       <= '0;
      disableQ   <= 1'b1;
      resetPendQ <= 1'b1;
    end else begin
      reqQ <= (reqQ & swKeep & ~strb.clrReq) | setVec;
      if (wrEnLo) enQ[7:0] <= regWrData;
      if (wrEnHi) enQ[NUM_MASK-1:8] <= regWrData[HI_W-1:0];
      if (wrPol)  polQ <= regWrData[NUM_EXT-1:0];
      if (strb.setDisable) disableQ <= 1'b1;
      else if (wrStat)     disableQ <= regWrData[0];
      if (strb.clrReset) resetPendQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      A_REQ_LO: regRdData = reqQ[7:0];
      A_REQ_HI: regRdData = {{(8-HI_W){1'b0}}, reqQ[NUM_MASK-1:8]};
      A_EN_LO:  regRdData = enQ[7:0];
      A_EN_HI:  regRdData = {{(8-HI_W){1'b0}}, enQ[NUM_MASK-1:8]};
      A_POL:    regRdData = {{(8-NUM_EXT){1'b0}}, polQ};
      A_STAT:   regRdData = {7'd0, disableQ};
      default:  regRdData = 8'd0;
    endcase
  end

  // R3: a write never creates a request bit
  p_sw_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReqLo && setVec[7:0] == 8'd0) |=> ((reqQ[7:0] & ~$past(reqQ[7:0])) == 8'd0));

  // R6: acknowledge raises the mask flag
  p_ack_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setDisable |=> disableQ);

  // R9: hardware set wins over any clear
  for (genvar b = 0; b < NUM_MASK; b++) begin : g_hwWins
    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      setVec[b] |=> reqQ[b]);
  end
endmodule

// File: rtl/irqc_control.sv
`timescale 1ns/1ps
module irqc_control
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MASK-1:0] reqQ,
  input  logic [NUM_MASK-1:0] enQ,
  input  logic                disableQ,
  input  logic                resetPendQ,
  input  logic                brkReq,
  input  logic                irqAck,
  output strobe_t             strb,
  output logic                irqValid,
  output logic [IDX_W-1:0]    irqSource,
  output logic [15:0]         irqVector
);
  logic [NUM_MASK-1:0] ready;
  logic                candHit, gValid, taken;
  logic [IDX_W-1:0]    candIdx, gIdx;

  assign ready = reqQ & enQ & {NUM_MASK{~disableQ}};

  always_comb begin
    candHit = 1'b0;
    candIdx = IDX_RESET;
    if (resetPendQ) begin
      candHit = 1'b1;
    end else begin
      for (int i = NUM_MASK-1; i >= 0; i--) begin
        if (ready[i]) begin
          candHit = 1'b1;
          candIdx = IDX_W'(i + 1);
        end
      end
      if (!candHit && brkReq) begin
        candHit = 1'b1;
        candIdx = IDX_BRK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gValid <= 1'b0;
      gIdx   <= IDX_RESET;
    end else if (!gValid && candHit) begin
      gValid <= 1'b1;
      gIdx   <= candIdx;
    end else if (taken) begin
      gValid <= 1'b0;
    end
  end

  assign taken           = gValid && irqAck;
  assign strb.setDisable = taken;
  assign strb.clrReset   = taken && (gIdx == IDX_RESET);
  for (genvar m = 0; m < NUM_MASK; m++) begin : g_clr
    assign strb.clrReq[m] = taken && (gIdx == IDX_W'(m + 1));
  end

  assign irqValid  = gValid;
  assign irqSource = gIdx;
  assign irqVector = vecOf(gIdx);

  // R8: presented entry is frozen until acknowledge
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gValid && !irqAck) |=> (gValid && $stable(gIdx)));
  // R6: acknowledge drops the presentation
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gValid && irqAck) |=> !gValid);
  // R6: at most one clear per acknowledge
  p_one_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.clrReq, strb.clrReset}));
  // R2: a maskable entry starts only with the mask flag clear
  p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gValid && !$past(gValid) && gIdx != IDX_RESET && gIdx != IDX_BRK) |-> !$past(disableQ));
  // R5: pending reset is always chosen first
  p_reset_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gValid && resetPendQ) |=> (gValid && gIdx == IDX_RESET));
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EXT-1:0]  extPin,
  input  logic [NUM_INT-1:0]  intEvt,
  input  logic                brkReq,
  input  logic [2:0]          regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                irqAck,
  output logic                irqValid,
  output logic [IDX_W-1:0]    irqSource,
  output logic [15:0]         irqVector
);
  strobe_t             strb;
  logic [NUM_MASK-1:0] reqQ, enQ;
  logic                disableQ, resetPendQ;

  irqc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .intEvt(intEvt),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .strb(strb), .reqQ(reqQ), .enQ(enQ),
    .disableQ(disableQ), .resetPendQ(resetPendQ)
  );

  irqc_control u_ctl (
    .clk(clk), .rst_n(rst_n), .reqQ(reqQ), .enQ(enQ), .disableQ(disableQ),
    .resetPendQ(resetPendQ), .brkReq(brkReq), .irqAck(irqAck), .strb(strb),
    .irqValid(irqValid), .irqSource(irqSource), .irqVector(irqVector)
  );
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] extPin = 0;
  logic [8:0] intEvt = 0;
  logic brkReq = 0, regWrEn = 0, irqAck = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic irqValid;
  logic [3:0] irqSource;
  logic [15:0] irqVector;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .intEvt(intEvt), .brkReq(brkReq),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqAck(irqAck), .irqValid(irqValid),
    .irqSource(irqSource), .irqVector(irqVector)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [11:0] mReq, mEn;
  logic [2:0]  mPol, mS1, mS2, mPrev;
  logic        mI, mRp, mV;
  int          mIdx;

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      0: return mReq[7:0];
      1: return {4'd0, mReq[11:8]};
      2: return mEn[7:0];
      3: return {4'd0, mEn[11:8]};
      4: return {5'd0, mPol};
      5: return {7'd0, mI};
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [11:0] setv, keep, nextReq;
    logic [2:0] edg;
    int pick;
    bit taken;
    if (!rst_n) begin
      mReq = 0; mEn = 0; mPol = 0; mS1 = 0; mS2 = 0; mPrev = 0;
      mI = 1; mRp = 1; mV = 0; mIdx = 0;
    end else begin
      edg = 0;
      for (int k = 0; k < 3; k++)
        if (mS2[k] != mPrev[k]) edg[k] = (mPol[k] == 0) ? mS2[k] : !mS2[k];
      setv[0] = intEvt[0]; setv[1] = edg[1]; setv[2] = edg[0]; setv[11] = edg[2];
      for (int k = 3; k <= 10; k++) setv[k] = intEvt[k-2];
      keep = 12'hFFF;
      if (regWrEn && regAddr == 0) keep[7:0] = regWrData;
      if (regWrEn && regAddr == 1) keep[11:8] = regWrData[3:0];
      taken = mV && irqAck;
      pick = -1;
      if (mRp) pick = 0;
      else begin
        for (int k = 1; k <= 12; k++)
          if (pick < 0 && mReq[k-1] && mEn[k-1] && !mI) pick = k;
        if (pick < 0 && brkReq) pick = 13;
      end
      nextReq = mReq & keep;
      if (taken && mIdx >= 1 && mIdx <= 12) nextReq[mIdx-1] = 1'b0;
      nextReq = nextReq | setv;
      if (regWrEn && regAddr == 2) mEn[7:0] = regWrData;
      if (regWrEn && regAddr == 3) mEn[11:8] = regWrData[3:0];
      if (regWrEn && regAddr == 4) mPol = regWrData[2:0];
      if (taken) mI = 1;
      else if (regWrEn && regAddr == 5) mI = regWrData[0];
      if (taken && mIdx == 0) mRp = 0;
      if (!mV && pick >= 0) begin mV = 1; mIdx = pick; end
      else if (taken) mV = 0;
      mReq = nextReq;
      mPrev = mS2; mS2 = mS1; mS1 = extPin;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 valid vs model", {15'd0, irqValid}, {15'd0, mV});
      if (mV) begin
        check("R5 source vs model", {12'd0, irqSource}, 16'(mIdx));
        check("R8 vector vs model", irqVector, 16'hFFFE - 16'(2*mIdx));
      end
      check("R4 readback vs model", {8'd0, regRdData}, {8'd0, mRead(regAddr)});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1; tick(); regWrEn = 0;
  endtask
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    regAddr = a; #1; check(tag, {8'd0, regRdData}, {8'd0, e});
  endtask
  task automatic pulse(input logic [8:0] p);
    intEvt = p; tick(); intEvt = 0;
  endtask
  task automatic ack();
    irqAck = 1; tick(); irqAck = 0;
  endtask
  task automatic expIrq(input logic [3:0] src, input string tag);
    check({tag, " valid"}, {15'd0, irqValid}, 16'd1);
    check({tag, " source"}, {12'd0, irqSource}, {12'd0, src});
    check({tag, " vector"}, irqVector, 16'hFFFE - {11'd0, src, 1'b0});
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1: reset state and reset entry
    rd(0, 8'h00, "R1 req lo"); rd(2, 8'h00, "R1 en lo");
    rd(4, 8'h00, "R1 pol");    rd(5, 8'h01, "R1 mask flag");
    tick();
    expIrq(0, "R1 reset entry");
    ack();
    check("R6 valid dropped", {15'd0, irqValid}, 16'd0);
    // R4: enables and mask flag
    wr(2, 8'hFF); wr(3, 8'hFF); wr(5, 8'h00);
    rd(3, 8'h0F, "R4 en hi upper ignored"); rd(5, 8'h00, "R4 mask flag cleared");
    // R10: timer 1 pulse -> entry 9
    pulse(9'h040); tick();
    expIrq(9, "R10 timer entry");
    // R8: more urgent source does not disturb presented entry
    pulse(9'h001); tick();
    expIrq(9, "R8 hold");
    ack();
    rd(5, 8'h01, "R6 mask set by ack");
    rd(1, 8'h00, "R6 taken request cleared");
    rd(0, 8'h01, "R2 display pending");
    check("R2 masked no valid", {15'd0, irqValid}, 16'd0);
    wr(5, 8'h00); tick();
    expIrq(1, "R2 unmask display");
    ack();
    // R3: writes only clear
    pulse(9'h010);
    rd(0, 8'h40, "R3 timer3 pending");
    wr(0, 8'hFF); rd(0, 8'h40, "R3 write ones no effect");
    wr(1, 8'hF0); rd(1, 8'h00, "R3 hi upper bits ignored");
    wr(0, 8'hBF); rd(0, 8'h00, "R3 write zero clears");
    // R9: hardware set same cycle as clear
    regAddr = 0; regWrData = 8'h00; regWrEn = 1; intEvt = 9'h010; tick();
    regWrEn = 0; intEvt = 0;
    rd(0, 8'h40, "R9 set beats clear");
    wr(0, 8'h00);
    // R7: pin 0 edges (request bit 2)
    extPin[0] = 1; tick(); tick();
    rd(0, 8'h00, "R7 not yet after two edges");
    tick(); rd(0, 8'h04, "R7 rising seen after three edges");
    wr(0, 8'h00);
    extPin[0] = 0; repeat (4) tick();
    rd(0, 8'h00, "R7 falling ignored at polarity 0");
    wr(4, 8'h01);
    extPin[0] = 1; repeat (4) tick();
    rd(0, 8'h00, "R7 rising ignored at polarity 1");
    extPin[0] = 0; repeat (4) tick();
    rd(0, 8'h04, "R7 falling seen at polarity 1");
    wr(0, 8'h00);
    // R2: enable gating
    wr(2, 8'h00); wr(3, 8'h00); wr(5, 8'h00);
    pulse(9'h080); tick(); tick();
    check("R2 disabled no valid", {15'd0, irqValid}, 16'd0);
    wr(3, 8'h02); tick();
    expIrq(10, "R2 enabled serial");
    ack();
    // R5: priority among simultaneous sources
    wr(2, 8'hFF); wr(3, 8'h0F);
    pulse(9'h102);
    wr(5, 8'h00); tick();
    expIrq(4, "R5 higher of two");
    ack(); wr(5, 8'h00); tick();
    expIrq(11, "R5 lower of two");
    ack();
    // R5: break is unmaskable
    rd(5, 8'h01, "R5 masked before break");
    brkReq = 1; tick(); tick();
    expIrq(13, "R5 break while masked");
    irqAck = 1; tick(); irqAck = 0; brkReq = 0;
    tick();
    check("R6 break done", {15'd0, irqValid}, 16'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule